// File: doc/BRIEF.md
# Display bus host sequencer

This block is the host-side engine for a parallel character display bus. User logic hands it one request at a time over a valid/ready handshake. A request names one of four bus operations (instruction write, data write, data read, status read) and, for writes, the byte to send. The engine drives the register-select and read/write levels and the data bus. It then produces one enable strobe with counted setup, high and hold phases. For read requests it hands the sampled byte back to the user.

After any request that starts work inside the display, the engine waits before it accepts the next request. In polling mode it issues status reads back to back until the busy bit comes back clear. It then adds a guard interval of at least half a period of the display's 270 kHz oscillator before it reports ready again. If the busy bit stays set for a parameterized number of polls, it emits an error pulse and falls back to the timed wait. In timed mode it waits a fixed time chosen from the request. The long wait applies to the clear and home instructions, and there is a shorter wait for other instructions and one for data transfers. All times derive from the parameter giving clock cycles per microsecond.

Top module: `disp_bus_seq`

## Requirements
- R1: `req_ready` is high only while the engine is idle. It falls in the cycle after a request is accepted and stays low until that request's strobe and its wait or guard have completed.
- R2: Bus levels per request kind (`req_kind` encoding 0 = instruction write, 1 = data write, 2 = data read, 3 = status read): `lcd_rs`/`lcd_rw` are 0/0, 1/0, 1/1 and 0/1 respectively. Internally generated polls use 0/1.
- R3: Each transfer holds `lcd_rs`, `lcd_rw` and `lcd_dout` for SETUP_CYC cycles with `lcd_e` low. It then raises `lcd_e` for exactly HIGH_CYC cycles and keeps the levels for HOLD_CYC cycles after `lcd_e` falls.
- R4: `lcd_doe` is high only during the setup, high and hold phases of a write, with `lcd_dout` equal to the request byte. It is low during reads and between transfers.
- R5: For user read requests, `lcd_din` is sampled in the last cycle of `lcd_e` high. It is returned on `rsp_byte` with a one-cycle `rsp_valid` pulse in the first cycle after `lcd_e` falls. Polls never pulse `rsp_valid`.
- R6: In polling mode, after a request of kind 0, 1 or 2, status reads are issued one after another until a poll returns bit 7 of `lcd_din` clear.
- R7: After a poll returns busy clear, `req_ready` rises GUARD_CYC cycles after that poll's hold phase ends. GUARD_CYC is the ceiling of 1.852 us in clock cycles, at least 1.
- R8: If POLL_LIMIT consecutive polls all return busy set, `timeout_err` pulses for exactly one cycle and the engine then runs the timed wait for the request.
- R9: In timed mode, the wait after the hold phase is 1530·CYC_PER_US cycles for instruction byte 0x01 and for 0x02/0x03. It is 39·CYC_PER_US cycles for any other instruction and 43·CYC_PER_US cycles for data writes and reads.
- R10: A user status read incurs no wait and no polling: `req_ready` returns in the first cycle after its hold phase. `rsp_byte` carries the busy bit in bit 7 and the address counter in bits 6..0.
- R11: During and after reset with no request: `req_ready`=1, `lcd_e`=0, `lcd_doe`=0, `rsp_valid`=0, `timeout_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| poll_en | input | 1 | 1 = poll the busy bit, 0 = timed wait; taken with each request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_kind | input | 2 | 0 instr write, 1 data write, 2 data read, 3 status read |
| req_byte | input | 8 | Byte to write (ignored for reads) |
| rsp_valid | output | 1 | One-cycle pulse: read result available |
| rsp_byte | output | 8 | Read data, or busy bit and address counter |
| timeout_err | output | 1 | One-cycle pulse on poll timeout |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_e | output | 1 | Enable strobe |
| lcd_dout | output | 8 | Data bus output value |
| lcd_doe | output | 1 | Data bus output enable (tri-state control) |
| lcd_din | input | 8 | Data bus input value |

## Verification
The assertions assume that `req_kind`, `req_byte` and `poll_en` are stable while `req_valid` is high. They also assume that `lcd_din` has settled by the last cycle of `lcd_e` high, as a display answering within the high time would. The stimulus drives requests only from the idle state and at the falling clock edge, and keeps the mode fixed for each request. A behavioural display model in the bench answers reads combinationally. That model re-arms its busy count on the falling strobe of every non-status transfer and counts it down on each status read. The busy periods are chosen to end before, at and beyond the poll limit.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_WDATA = 2'd1,
    K_RDATA = 2'd2,
    K_STAT  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_HIGH  = 3'd2,
    S_HOLD  = 3'd3,
    S_GUARD = 3'd4,
    S_WAIT  = 3'd5
  } seq_state_e;

  function automatic logic is_long_cmd(input logic [7:0] b);
    return (b == 8'h01) || (b[7:1] == 7'd1);
  endfunction

endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/disp_cnt.sv
module disp_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/disp_wait_sel.sv
module disp_wait_sel
  import disp_bus_pkg::*;
#(
  parameter int CW        = 8,
  parameter int LONG_CYC  = 100,
  parameter int INSTR_CYC = 10,
  parameter int DATA_CYC  = 11
) (
  input  req_kind_e     kind,
  input  logic [7:0]    cmd_byte,
  output logic [CW-1:0] wait_ld
);
  always_comb begin
    if (kind == K_CMD) begin
      if (is_long_cmd(cmd_byte)) wait_ld = CW'(LONG_CYC - 1);
      else                       wait_ld = CW'(INSTR_CYC - 1);
    end else begin
      wait_ld = CW'(DATA_CYC - 1);
    end
  end
endmodule

// File: rtl/disp_bus_seq.sv
module disp_bus_seq
  import disp_bus_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int SETUP_CYC  = 2,
  parameter int HIGH_CYC   = 4,
  parameter int HOLD_CYC   = 2,
  parameter int POLL_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_en,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_byte,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic       timeout_err,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_dout,
  output logic       lcd_doe,
  input  logic [7:0] lcd_din
);
  localparam int LONG_CYC  = 1530 * CYC_PER_US;
  localparam int INSTR_CYC = 39 * CYC_PER_US;
  localparam int DATA_CYC  = 43 * CYC_PER_US;
  localparam int GUARD_RAW = (1852 * CYC_PER_US + 999) / 1000;
  localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int CW        = $clog2(LONG_CYC + 1);
  localparam int PW        = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CYC - 1);
  localparam logic [PW-1:0] PCNT_TOP = PW'(POLL_LIMIT - 1);

  logic rst_i_n;

  disp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  seq_state_e    state_q, state_d;
  req_kind_e     kind_q, kind_d;
  logic [7:0]    byte_q, byte_d;
  logic          mode_q, mode_d;
  logic          polling_q, polling_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          rs_q, rs_d;
  logic          rw_q, rw_d;
  logic          busy_q, busy_d;
  logic [7:0]    rsp_byte_q, rsp_byte_d;
  logic          rsp_valid_q, rsp_valid_d;
  logic          err_q, err_d;

  logic          cnt_ld, cnt_last;
  logic [CW-1:0] cnt_val, wait_ld;
  logic          accept, sample, start_poll, poll_expire, in_xfer;

  disp_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_ld),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  disp_wait_sel #(
    .CW        (CW),
    .LONG_CYC  (LONG_CYC),
    .INSTR_CYC (INSTR_CYC),
    .DATA_CYC  (DATA_CYC)
  ) u_wait (
    .kind     (kind_q),
    .cmd_byte (byte_q),
    .wait_ld  (wait_ld)
  );

  assign accept  = (state_q == S_IDLE) && req_valid;
  assign sample  = (state_q == S_HIGH) && cnt_last;
  assign in_xfer = (state_q == S_SETUP) || (state_q == S_HIGH) || (state_q == S_HOLD);

  // Phase sequencing
  always_comb begin
    state_d     = state_q;
    cnt_ld      = 1'b0;
    cnt_val     = '0;
    start_poll  = 1'b0;
    poll_expire = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          state_d = S_SETUP;
          cnt_ld  = 1'b1;
          cnt_val = SETUP_LD;
        end
      end
      S_SETUP: begin
        if (cnt_last) begin
          state_d = S_HIGH;
          cnt_ld  = 1'b1;
          cnt_val = HIGH_LD;
        end
      end
      S_HIGH: begin
        if (cnt_last) begin
          state_d = S_HOLD;
          cnt_ld  = 1'b1;
          cnt_val = HOLD_LD;
        end
      end
      S_HOLD: begin
        if (cnt_last) begin
          if (polling_q) begin
            if (!busy_q) begin
              state_d = S_GUARD;
              cnt_ld  = 1'b1;
              cnt_val = GUARD_LD;
            end else if (pcnt_q == PCNT_TOP) begin
              poll_expire = 1'b1;
              state_d     = S_WAIT;
              cnt_ld      = 1'b1;
              cnt_val     = wait_ld;
            end else begin
              start_poll = 1'b1;
              state_d    = S_SETUP;
              cnt_ld     = 1'b1;
              cnt_val    = SETUP_LD;
            end
          end else if (kind_q == K_STAT) begin
            state_d = S_IDLE;
          end else if (mode_q) begin
            start_poll = 1'b1;
            state_d    = S_SETUP;
            cnt_ld     = 1'b1;
            cnt_val    = SETUP_LD;
          end else begin
            state_d = S_WAIT;
            cnt_ld  = 1'b1;
            cnt_val = wait_ld;
          end
        end
      end
      S_GUARD, S_WAIT: begin
        if (cnt_last) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Request and capture registers, next values
  always_comb begin
    kind_d    = kind_q;
    byte_d    = byte_q;
    mode_d    = mode_q;
    polling_d = polling_q;
    pcnt_d    = pcnt_q;
    rs_d      = rs_q;
    rw_d      = rw_q;
    if (accept) begin
      kind_d    = req_kind_e'(req_kind);
      byte_d    = req_byte;
      mode_d    = poll_en;
      polling_d = 1'b0;
      rs_d      = (req_kind == K_WDATA) || (req_kind == K_RDATA);
      rw_d      = req_kind[1];
    end else if (start_poll) begin
      polling_d = 1'b1;
      rs_d      = 1'b0;
      rw_d      = 1'b1;
      pcnt_d    = polling_q ? pcnt_q + PW'(1) : '0;
    end
    busy_d      = sample ? lcd_din[7] : busy_q;
    rsp_valid_d = sample && !polling_q && rw_q;
    rsp_byte_d  = rsp_valid_d ? lcd_din : rsp_byte_q;
    err_d       = poll_expire;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= S_IDLE;
      kind_q      <= K_CMD;
      byte_q      <= '0;
      mode_q      <= 1'b0;
      polling_q   <= 1'b0;
      pcnt_q      <= '0;
      rs_q        <= 1'b0;
      rw_q        <= 1'b0;
      busy_q      <= 1'b0;
      rsp_byte_q  <= '0;
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (accept || start_poll) begin
        kind_q    <= kind_d;
        byte_q    <= byte_d;
        mode_q    <= mode_d;
        polling_q <= polling_d;
        pcnt_q    <= pcnt_d;
        rs_q      <= rs_d;
        rw_q      <= rw_d;
      end
      if (sample) busy_q <= busy_d;
      if (rsp_valid_d) rsp_byte_q <= rsp_byte_d;
      rsp_valid_q <= rsp_valid_d;
      err_q       <= err_d;
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign lcd_e       = (state_q == S_HIGH);
  assign lcd_rs      = rs_q;
  assign lcd_rw      = rw_q;
  assign lcd_doe     = in_xfer && !rw_q;
  assign lcd_dout    = byte_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_byte    = rsp_byte_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/disp_bus_seq_chk.sv
module disp_bus_seq_chk #(
  parameter int HIGH_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       timeout_err,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] lcd_dout,
  input logic       lcd_doe
);
  logic [15:0] e_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_run_q <= '0;
    else if (lcd_e) e_run_q <= e_run_q + 16'd1;
    else            e_run_q <= '0;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_STROBE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready); // R1
  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout))); // R3
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (e_run_q == 16'(HIGH_CYC))); // R3
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_doe |-> !lcd_rw); // R4
  AST_STROBE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> (lcd_doe != lcd_rw)); // R2
  AST_RSP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($fell(lcd_e) && lcd_rw)); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err); // R8
  AST_ERR_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!req_ready && !lcd_e)); // R8
endmodule

bind disp_bus_seq disp_bus_seq_chk #(.HIGH_CYC(HIGH_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .timeout_err (timeout_err),
  .lcd_rs      (lcd_rs),
  .lcd_rw      (lcd_rw),
  .lcd_e       (lcd_e),
  .lcd_dout    (lcd_dout),
  .lcd_doe     (lcd_doe)
);

// File: tb/disp_bus_seq_test.sv
module disp_bus_seq_test;
  localparam int CPU   = 1;
  localparam int SETUP = 2;
  localparam int HIGH  = 3;
  localparam int HOLD  = 2;
  localparam int PLIM  = 4;
  localparam int GUARD = 2;

  logic       clk;
  logic       rst_n;
  logic       poll_en;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_kind;
  logic [7:0] req_byte;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       timeout_err;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_doe;
  logic [7:0] lcd_dout, lcd_din;

  int checks;
  int fails;

  // display model
  int         dev_busy_left;
  int         dev_busy_arm;
  logic [6:0] dev_ac;
  logic [7:0] dev_rdata;

  disp_bus_seq #(
    .CYC_PER_US (CPU),
    .SETUP_CYC  (SETUP),
    .HIGH_CYC   (HIGH),
    .HOLD_CYC   (HOLD),
    .POLL_LIMIT (PLIM)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_en     (poll_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_byte    (req_byte),
    .rsp_valid   (rsp_valid),
    .rsp_byte    (rsp_byte),
    .timeout_err (timeout_err),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_e       (lcd_e),
    .lcd_dout    (lcd_dout),
    .lcd_doe     (lcd_doe),
    .lcd_din     (lcd_din)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    if (!lcd_rs && lcd_rw) lcd_din = {(dev_busy_left != 0), dev_ac};
    else                   lcd_din = dev_rdata;
  end

  always @(negedge lcd_e) begin
    if (!lcd_rs && lcd_rw) begin
      if (dev_busy_left > 0) dev_busy_left = dev_busy_left - 1;
    end else begin
      dev_busy_left = dev_busy_arm;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle of the reference model, compared at the falling edge
  task automatic step(input string rtag, input logic e_rdy, input logic xfer,
                      input logic e_e, input logic e_rs, input logic e_rw,
                      input logic e_doe, input logic [7:0] e_dout,
                      input logic e_rv, input logic [7:0] e_rb, input logic e_err);
    @(negedge clk);
    chk(rtag, "req_ready", req_ready, e_rdy);
    chk("R3", "lcd_e", lcd_e, e_e);
    if (xfer) begin
      chk("R2", "lcd_rs", lcd_rs, e_rs);
      chk("R2", "lcd_rw", lcd_rw, e_rw);
    end
    chk("R4", "lcd_doe", lcd_doe, e_doe);
    if (e_doe) chk("R4", "lcd_dout", lcd_dout, e_dout);
    chk("R5", "rsp_valid", rsp_valid, e_rv);
    if (e_rv) chk("R5_R10", "rsp_byte", rsp_byte, e_rb);
    chk("R8", "timeout_err", timeout_err, e_err);
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] b,
                      input logic rv, input logic [7:0] rb, input logic first);
    for (int i = 0; i < SETUP; i++) begin
      step("R1", 1'b0, 1'b1, 1'b0, rs, rw, !rw, b, 1'b0, 8'h00, 1'b0);
      if (first && i == 0) req_valid = 1'b0;
    end
    for (int i = 0; i < HIGH; i++)
      step("R1", 1'b0, 1'b1, 1'b1, rs, rw, !rw, b, 1'b0, 8'h00, 1'b0);
    for (int i = 0; i < HOLD; i++)
      step("R1", 1'b0, 1'b1, 1'b0, rs, rw, !rw, b, rv && (i == 0), rb, 1'b0);
  endtask

  task automatic idle_steps(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(tag, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic wait_steps(input int n, input logic first_err, input string tag);
    for (int i = 0; i < n; i++)
      step(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00,
           first_err && (i == 0));
  endtask

  function automatic int exp_wait(input logic [1:0] k, input logic [7:0] b);
    if (k == 2'd0) begin
      if (b == 8'h01 || b == 8'h02 || b == 8'h03) return 1530 * CPU;
      return 39 * CPU;
    end
    return 43 * CPU;
  endfunction

  task automatic run_req(input logic [1:0] k, input logic [7:0] b,
                         input logic poll, input int arm, input string wtag);
    logic       rs, rw, rv;
    logic [7:0] rb;
    dev_busy_arm = arm;
    rs = (k == 2'd1) || (k == 2'd2);
    rw = k[1];
    rv = k[1];
    rb = (k == 2'd3) ? {(dev_busy_left != 0), dev_ac} : dev_rdata;
    req_kind  = k;
    req_byte  = b;
    poll_en   = poll;
    req_valid = 1'b1;
    xfer(rs, rw, b, rv, rb, 1'b1);
    if (k == 2'd3) begin
      idle_steps(1, "R10");
    end else if (poll) begin
      for (int i = 0; i < PLIM; i++) begin
        xfer(1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0);
        if (i >= arm) begin
          wait_steps(GUARD, 1'b0, "R7");
          break;
        end
        if (i == PLIM - 1) wait_steps(exp_wait(k, b), 1'b1, "R8");
      end
      idle_steps(1, wtag);
    end else begin
      wait_steps(exp_wait(k, b), 1'b0, wtag);
      idle_steps(1, wtag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks        = 0;
    fails         = 0;
    dev_busy_left = 0;
    dev_busy_arm  = 0;
    dev_ac        = 7'h15;
    dev_rdata     = 8'h5A;
    rst_n         = 1'b0;
    poll_en       = 1'b0;
    req_valid     = 1'b0;
    req_kind      = 2'd0;
    req_byte      = 8'h00;
    idle_steps(3, "R11");
    rst_n = 1'b1;
    idle_steps(4, "R11");

    // R9: timed waits per request
    run_req(2'd0, 8'h38, 1'b0, 0, "R9");   // short instruction
    run_req(2'd0, 8'h01, 1'b0, 0, "R9");   // clear, long
    run_req(2'd0, 8'h03, 1'b0, 0, "R9");   // home, long
    run_req(2'd0, 8'h02, 1'b0, 0, "R9");   // home, long
    run_req(2'd0, 8'h04, 1'b0, 0, "R9");   // just above home, short
    run_req(2'd1, 8'h41, 1'b0, 0, "R9");   // data write
    dev_rdata = 8'hC3;
    run_req(2'd2, 8'h00, 1'b0, 0, "R9");   // data read, R5

    // R10: user status reads, idle and busy
    dev_busy_left = 0;
    run_req(2'd3, 8'h00, 1'b0, 0, "R10");
    dev_busy_left = 1;
    dev_ac = 7'h6E;
    run_req(2'd3, 8'h00, 1'b1, 0, "R10");

    // R6/R7: polling until clear, then guard
    run_req(2'd0, 8'h0C, 1'b1, 2, "R6");
    run_req(2'd1, 8'h7E, 1'b1, 0, "R6");
    dev_rdata = 8'h9B;
    run_req(2'd2, 8'h00, 1'b1, 1, "R6");
    run_req(2'd0, 8'h06, 1'b1, PLIM - 1, "R6");

    // R8: poll limit reached, error pulse then timed wait
    run_req(2'd0, 8'h10, 1'b1, PLIM + 5, "R8");
    run_req(2'd0, 8'h01, 1'b1, PLIM, "R8");

    idle_steps(3, "R11");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule